// File: doc/BRIEF.md
# Audio Stream Sync Deframer

This block takes the payload of isochronous audio packets as a stream of 32-bit quadlets and splits it into two products. The first is a stream of 24-bit audio samples, each tagged with its channel number. The second is a set of synchronisation fields that the sender hides in the low bytes of particular channels. Each packet opens with two header quadlets, which the block drops. The payload then follows directly as sample-frames of 28 quadlets, one per channel. Each quadlet carries the audio value in its upper three bytes.

The low bytes of channels 0 to 7 hold the sync data. This data is repeated in channels 8 to 27. For every sample-frame the block gathers the current frame number, the phase, a 16-bit receive sample counter and a 16-bit transmit buffer size. It checks that every repeated low byte agrees with its primary copy. It also checks that the receive counter advanced by exactly one since the previous sample-frame. The frame number may change inside a packet, so the fields are refreshed once per sample-frame and not once per packet.

The input and the audio output both use a valid/ready handshake. A single output register makes the input ready whenever that register is empty or being drained.

Top module: `audio_sync_deframer`

## Requirements
- R1: An input quadlet with `in_sop_i` high opens a packet and is the first of two header quadlets. The header quadlets and any quadlet accepted while no packet is open produce no audio output.
- R2: Each payload quadlet produces one output beat. `out_sample_o` equals input bits 31:8. `out_chan_o` counts 0 to 27 and then wraps to 0 for the next sample-frame.
- R3: A packet holds 7 sample-frames (196 payload quadlets). `out_last_o` is high only on channel 27 of the seventh sample-frame, and that beat closes the packet.
- R4: `sync_valid_o` pulses for one cycle in the cycle where the channel-27 beat of a sample-frame first appears at the output. With that pulse the block presents the sync fields of the frame: `frame_o` from the low byte of channel 6, `phase_o` from channel 7, `rx_cnt_o` as {channel 4, channel 1}, and `tx_buf_o` as {channel 5, channel 0}.
- R5: `mismatch_o` is high with the pulse when, for any channel k from 8 to 27, the low byte of channel k differs from the low byte of channel k mod 8 in the same sample-frame.
- R6: `missed_o` is high with the pulse when the receive counter differs from the previous sample-frame's counter plus one, modulo 2^16. It is low for the first sample-frame after reset.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the output beat stays unchanged. `in_ready_o` equals `out_ready_i` or not `out_valid_o`, and no payload quadlet is lost or duplicated.
- R8: After reset `out_valid_o`, `sync_valid_o`, `mismatch_o` and `missed_o` are low, and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input quadlet valid |
| in_ready_o | output | 1 | Input quadlet accepted when valid |
| in_sop_i | input | 1 | First header quadlet of a packet |
| in_data_i | input | 32 | Input quadlet |
| out_valid_o | output | 1 | Audio beat valid |
| out_ready_i | input | 1 | Downstream accepts audio beat |
| out_sample_o | output | 24 | Audio sample |
| out_chan_o | output | 5 | Channel index 0..27 |
| out_last_o | output | 1 | Last payload quadlet of packet |
| sync_valid_o | output | 1 | Sync fields of a sample-frame presented |
| frame_o | output | 8 | Current frame number |
| phase_o | output | 8 | Phase |
| rx_cnt_o | output | 16 | Receive sample counter |
| tx_buf_o | output | 16 | Transmit buffer size |
| mismatch_o | output | 1 | A repeated low byte disagreed |
| missed_o | output | 1 | Receive counter discontinuity |

## Verification
A slipped channel or header counter shows at once as a wrong `out_chan_o` or `out_sample_o` on the next output beat. It also makes the sync pulse and `out_last_o` land on the wrong beat within one sample-frame. A stale primary low-byte register shows as a false `mismatch_o` or a wrong field on the very next sync pulse. A wrong previous-counter register shows as a wrong `missed_o` on the following sample-frame. The stimulus includes repeated-byte corruption in both the middle and the short last channel groups, a counter wrap through zero, a deliberate gap, back-pressure, and a reset in the middle of a run.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef logic [7:0] lo_t;
  // primary channels holding sync bytes
  localparam int unsigned TXL_CH = 0;
  localparam int unsigned RXL_CH = 1;
  localparam int unsigned RXH_CH = 4;
  localparam int unsigned TXH_CH = 5;
  localparam int unsigned FRM_CH = 6;
  localparam int unsigned PH_CH  = 7;
endpackage

// File: rtl/sdf_index.sv
module sdf_index #(
  parameter int unsigned NUM_CH = 28,
  parameter int unsigned SPP    = 7,
  parameter int unsigned HDR_Q  = 2,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned SAMP_W = (SPP > 1) ? $clog2(SPP) : 1,
  localparam int unsigned HDR_W  = $clog2(HDR_Q + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            beat_i,
  input  logic            sop_i,
  output logic            pay_o,
  output logic [CH_W-1:0] chan_o,
  output logic            last_o
);
  localparam logic [CH_W-1:0]   LAST_CH = CH_W'(NUM_CH - 1);
  localparam logic [SAMP_W-1:0] LAST_S  = SAMP_W'(SPP - 1);
  localparam logic [HDR_W-1:0]  HDR_RST = HDR_W'(HDR_Q - 1);

  logic              open_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [CH_W-1:0]   chan_q;
  logic [SAMP_W-1:0] samp_q;

  assign pay_o  = beat_i && !sop_i && open_q && (hdr_q == '0);
  assign chan_o = chan_q;
  assign last_o = (chan_q == LAST_CH) && (samp_q == LAST_S);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      hdr_q  <= '0;
      chan_q <= '0;
      samp_q <= '0;
    end else if (beat_i && sop_i) begin
      open_q <= 1'b1;
      hdr_q  <= HDR_RST;
      chan_q <= '0;
      samp_q <= '0;
    end else if (beat_i && open_q && hdr_q != '0) begin
      hdr_q <= hdr_q - 1'b1;
    end else if (pay_o) begin
      if (chan_q == LAST_CH) begin
        chan_q <= '0;
        if (samp_q == LAST_S) begin
          samp_q <= '0;
          open_q <= 1'b0;
        end else begin
          samp_q <= samp_q + 1'b1;
        end
      end else begin
        chan_q <= chan_q + 1'b1;
      end
    end
  end

  // R2
  chan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_q <= LAST_CH);
  // R3
  pkt_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_o && last_o |=> !pay_o);
endmodule

// File: rtl/sdf_sync.sv
module sdf_sync
  import sdf_pkg::*;
#(
  parameter int unsigned NUM_CH = 28,
  parameter int unsigned GROUP  = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned GRP_W = $clog2(GROUP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pay_i,
  input  logic [CH_W-1:0] chan_i,
  input  lo_t             lo_i,
  output logic            sync_valid_o,
  output lo_t             frame_o,
  output lo_t             phase_o,
  output logic [15:0]     rx_cnt_o,
  output logic [15:0]     tx_buf_o,
  output logic            mismatch_o,
  output logic            missed_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
  localparam logic [CH_W-1:0] GRP_LIM = CH_W'(GROUP);

  lo_t         prim_q [GROUP];
  logic        acc_q, have_prev_q;
  logic [15:0] prev_q;
  logic        is_copy, mism_now;
  logic [15:0] rx_cur;

  assign is_copy  = chan_i >= GRP_LIM;
  // copies map onto primaries by channel mod GROUP (GROUP is a power of two)
  assign mism_now = pay_i && is_copy && (lo_i != prim_q[chan_i[GRP_W-1:0]]);
  assign rx_cur   = {prim_q[RXH_CH], prim_q[RXL_CH]};

  for (genvar g = 0; g < GROUP; g++) begin : g_prim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prim_q[g] <= '0;
      else if (pay_i && chan_i == CH_W'(g)) prim_q[g] <= lo_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= 1'b0;
      have_prev_q  <= 1'b0;
      prev_q       <= '0;
      sync_valid_o <= 1'b0;
      frame_o      <= '0;
      phase_o      <= '0;
      rx_cnt_o     <= '0;
      tx_buf_o     <= '0;
      mismatch_o   <= 1'b0;
      missed_o     <= 1'b0;
    end else begin
      sync_valid_o <= 1'b0;
      if (pay_i) begin
        if (chan_i == '0) acc_q <= 1'b0;
        else              acc_q <= acc_q | mism_now;
        if (chan_i == LAST_CH) begin
          sync_valid_o <= 1'b1;
          frame_o      <= prim_q[FRM_CH];
          phase_o      <= prim_q[PH_CH];
          rx_cnt_o     <= rx_cur;
          tx_buf_o     <= {prim_q[TXH_CH], prim_q[TXL_CH]};
          mismatch_o   <= acc_q | mism_now;
          missed_o     <= have_prev_q && (rx_cur != prev_q + 16'd1);
          prev_q       <= rx_cur;
          have_prev_q  <= 1'b1;
        end
      end
    end
  end

  // R4
  sync_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_valid_o |=> !sync_valid_o);
  // R6
  missed_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_valid_o && !$past(have_prev_q) |-> !missed_o);
endmodule

// File: rtl/sdf_out.sv
module sdf_out #(
  parameter int unsigned CH_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [23:0]     sample_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            last_i,
  input  logic            ready_i,
  output logic            in_ready_o,
  output logic            valid_o,
  output logic [23:0]     sample_o,
  output logic [CH_W-1:0] chan_o,
  output logic            last_o
);
  assign in_ready_o = ready_i || !valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
      chan_o   <= '0;
      last_o   <= 1'b0;
    end else if (load_i) begin
      valid_o  <= 1'b1;
      sample_o <= sample_i;
      chan_o   <= chan_i;
      last_o   <= last_i;
    end else if (ready_i) begin
      valid_o  <= 1'b0;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(sample_o) && $stable(chan_o) && $stable(last_o));
endmodule

// File: rtl/audio_sync_deframer.sv
module audio_sync_deframer #(
  parameter int unsigned NUM_CH = 28,
  parameter int unsigned SPP    = 7,
  parameter int unsigned HDR_Q  = 2,
  parameter int unsigned GROUP  = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic            in_sop_i,
  input  logic [31:0]     in_data_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [23:0]     out_sample_o,
  output logic [CH_W-1:0] out_chan_o,
  output logic            out_last_o,
  output logic            sync_valid_o,
  output logic [7:0]      frame_o,
  output logic [7:0]      phase_o,
  output logic [15:0]     rx_cnt_o,
  output logic [15:0]     tx_buf_o,
  output logic            mismatch_o,
  output logic            missed_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic            beat, pay, last;
  logic [CH_W-1:0] chan;

  assign beat = in_valid_i && in_ready_o;

  sdf_index #(.NUM_CH(NUM_CH), .SPP(SPP), .HDR_Q(HDR_Q)) u_index (
    .clk_i, .rst_ni, .beat_i(beat), .sop_i(in_sop_i),
    .pay_o(pay), .chan_o(chan), .last_o(last)
  );

  sdf_sync #(.NUM_CH(NUM_CH), .GROUP(GROUP)) u_sync (
    .clk_i, .rst_ni, .pay_i(pay), .chan_i(chan), .lo_i(in_data_i[7:0]),
    .sync_valid_o, .frame_o, .phase_o, .rx_cnt_o, .tx_buf_o,
    .mismatch_o, .missed_o
  );

  sdf_out #(.CH_W(CH_W)) u_out (
    .clk_i, .rst_ni, .load_i(pay), .sample_i(in_data_i[31:8]), .chan_i(chan),
    .last_i(last), .ready_i(out_ready_i), .in_ready_o,
    .valid_o(out_valid_o), .sample_o(out_sample_o), .chan_o(out_chan_o),
    .last_o(out_last_o)
  );

  // R4
  sync_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_valid_o |-> out_valid_o && out_chan_o == LAST_CH);
  // R3
  last_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> out_chan_o == LAST_CH);
endmodule

// File: tb/tb_audio_sync_deframer.sv
module tb_audio_sync_deframer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 28;
  localparam int NSP = 7;
  // {rx_start16, frame8, phase8, txbuf16, corrupt_ch8 (FF none), gap_samp8 (FF none)}
  localparam logic [63:0] VEC [5] = '{
    {16'h0010, 8'h20, 8'h03, 16'h0102, 8'hFF, 8'hFF},
    {16'h0017, 8'h21, 8'h40, 16'h0304, 8'd12, 8'hFF},
    {16'hFFFC, 8'h7E, 8'h11, 16'hA55A, 8'd25, 8'hFF},
    {16'h0003, 8'h90, 8'h22, 16'h0800, 8'hFF, 8'd4},
    {16'h000B, 8'hFE, 8'h33, 16'h1234, 8'd23, 8'hFF}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, out_ready = 1;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last, sync_valid, mismatch, missed;
  logic [23:0] out_sample;
  logic [4:0] out_chan;
  logic [7:0] frame, phase;
  logic [15:0] rx_cnt, tx_buf;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_sync_deframer dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sop_i(in_sop), .in_data_i(in_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_sample_o(out_sample), .out_chan_o(out_chan),
    .out_last_o(out_last), .sync_valid_o(sync_valid), .frame_o(frame),
    .phase_o(phase), .rx_cnt_o(rx_cnt), .tx_buf_o(tx_buf),
    .mismatch_o(mismatch), .missed_o(missed)
  );

  int checks = 0, failures = 0, cyc = 0, lasts = 0;
  bit stall = 0, done = 0, b_have = 0;
  logic [15:0] b_prev;
  logic [29:0] exp_q[$];
  logic [49:0] sync_q[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic drive(logic [31:0] d, logic sop);
    @(negedge clk);
    cyc++;
    out_ready = stall ? (cyc % 3 != 0) : 1'b1;
    in_valid = 1; in_data = d; in_sop = sop;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0; out_ready = 1;
    end
  endtask

  function automatic logic [7:0] lo_of(int c, int s, logic [15:0] rx, logic [15:0] tx,
                                      logic [7:0] fr, logic [7:0] ph);
    case (c % 8)
      0: return tx[7:0];
      1: return rx[7:0];
      2: return 8'h5A;
      3: return 8'hC3 ^ 8'(s);
      4: return rx[15:8];
      5: return tx[15:8];
      6: return fr;
      default: return ph;
    endcase
  endfunction

  task automatic send_pkt(int p, logic [63:0] v);
    logic [15:0] rx0, tx;
    logic [7:0] fr0, ph0, cor, gap;
    {rx0, fr0, ph0, tx, cor, gap} = v;
    drive(32'hDEAD_BEE0, 1'b1);
    drive(32'hDEAD_BEE1, 1'b0);
    for (int s = 0; s < NSP; s++) begin
      logic [15:0] rx;
      logic [7:0] fr, ph;
      bit mm, ms;
      rx = rx0 + 16'(s) + ((gap != 8'hFF && s >= int'(gap)) ? 16'd1 : 16'd0);
      fr = fr0 + ((s >= 4) ? 8'd1 : 8'd0);
      ph = ph0 ^ 8'(s);
      mm = (cor != 8'hFF) && (s == 2);
      ms = b_have && (rx != b_prev + 16'd1);
      b_prev = rx; b_have = 1;
      sync_q.push_back({fr, ph, rx, tx, mm, ms});
      for (int c = 0; c < NCH; c++) begin
        logic [7:0] lo;
        logic [23:0] smp;
        lo = lo_of(c, s, rx, tx, fr, ph);
        if (mm && c == int'(cor)) lo = lo ^ 8'h01;
        smp = {8'(p), 8'(s), 8'(c)};
        exp_q.push_back({(s == NSP-1 && c == NCH-1), 5'(c), smp});
        drive({smp, lo}, 1'b0);
      end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; out_ready = 1;
  endtask

  // monitor: samples mid-cycle, after inputs settle
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        // R7 ready rule
        chk(in_ready == (out_ready || !out_valid), "R7 in_ready", in_ready, out_ready || !out_valid);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(0, "R1 unexpected beat", {out_chan, out_sample}, 0);
          else begin
            logic [29:0] e;
            e = exp_q.pop_front();
            chk({out_last, out_chan, out_sample} == e, "R2 beat", {out_last, out_chan, out_sample}, e);
            if (out_last) lasts++;
          end
        end
        if (sync_valid) begin
          if (sync_q.size() == 0) chk(0, "R4 unexpected sync", rx_cnt, 0);
          else begin
            logic [49:0] e;
            e = sync_q.pop_front();
            chk({frame, phase, rx_cnt, tx_buf} == e[49:2], "R4 fields", {frame, phase, rx_cnt, tx_buf}, e[49:2]);
            chk(mismatch == e[1], "R5 mismatch", mismatch, e[1]);
            chk(missed == e[0], "R6 missed", missed, e[0]);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R8 reset state
    chk(!out_valid && !sync_valid && !mismatch && !missed, "R8 reset outputs",
        {out_valid, sync_valid, mismatch, missed}, 0);
    @(negedge clk); rst_n = 1;
    // R1 quadlets before any packet opens are dropped
    drive(32'h1111_1111, 1'b0);
    drive(32'h2222_2222, 1'b0);
    drive(32'h3333_3333, 1'b0);
    idle(1); #2;
    chk(!out_valid, "R1 no packet open", out_valid, 0);
    for (int i = 0; i < 5; i++) begin
      stall = (i == 3);
      send_pkt(i, VEC[i]);
    end
    stall = 0;
    idle(5);
    chk(exp_q.size() == 0, "R7 all beats delivered", exp_q.size(), 0);
    chk(sync_q.size() == 0, "R4 all sync pulses", sync_q.size(), 0);
    chk(lasts == 5, "R3 one last per packet", lasts, 5);
    // R1 quadlets after a packet closed are dropped
    drive(32'h4444_4444, 1'b0);
    idle(2); #2;
    chk(!out_valid, "R1 closed packet", out_valid, 0);
    // R8 reset mid-run; R6 first frame after reset not flagged
    @(negedge clk); rst_n = 0;
    #2;
    chk(!out_valid && !sync_valid && !missed, "R8 mid reset", {out_valid, sync_valid, missed}, 0);
    @(negedge clk); rst_n = 1;
    b_have = 0;
    send_pkt(9, {16'h4000, 8'h01, 8'h02, 16'h0005, 8'hFF, 8'hFF});
    idle(5);
    chk(exp_q.size() == 0 && sync_q.size() == 0, "R6 after reset drained", exp_q.size(), 0);
    summary();
  end
endmodule